// File: doc/BRIEF.md
# I2C Target Address Matcher with Masked Slots

This block watches the SCL and SDA lines of an I2C target port and decides, for the first byte after each START, whether the device is being addressed. It holds four address slots. Each slot has its own 7-bit address and a 7-bit don't-care mask. It also supports a general-call enable, which sits in bit 0 of the first slot's address byte. Both lines pass through a two-flop synchronizer. START and STOP are then found on the system clock. After the eighth rising SCL edge the block latches its result: whether any slot matched, which slot matched, whether a general call was seen, and the read/write bit.

Surrounding logic uses the result to decide whether to acknowledge. The result stays constant through the data phase and is cleared by the next START or STOP. While the controller is acting as bus master, the address configuration is ignored and no hit is reported.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are seen on synchronized samples, and either one clears `addrValid`, `addrHit`, `hitSlot`, `gcHit` and `rwBit` to 0.
- R2: After a START, eight bits are taken MSB first on the rising edges of SCL. The first seven form the received address and the eighth is the direction, captured on `rwBit` (0 = write, 1 = read).
- R3: Slot i takes its address from bits 8i+7:8i+1 of `ownAddrCfg` and its mask from bits 8i+7:8i+1 of `addrMaskCfg`. A mask bit of 1 makes that address bit don't-care, and a mask bit of 0 demands equality.
- R4: `addrHit` is 1 when at least one slot matches.
- R5: When several slots match, `hitSlot` gives the lowest-numbered one. `hitSlot` is 0 whenever `addrHit` is 0.
- R6: `gcHit` is 1 when the received byte is 0x00 and bit 0 of `ownAddrCfg` is 1. With that bit at 0, a 0x00 byte gives `gcHit` = 0.
- R7: Suppose SCL rises at the pin for the eighth bit just after a clock edge. Then `addrValid` is still 0 after the second following clock edge and is 1 after the third (two synchronizer stages plus one decision register).
- R8: If `masterMode` is 1 in the decision cycle, `addrHit`, `gcHit` and `hitSlot` are 0 while `addrValid` still rises.
- R9: SCL edges after the eighth bit and before the next START or STOP have no effect on any output.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line, asynchronous |
| sdaIn | input | 1 | SDA line, asynchronous |
| masterMode | input | 1 | Controller is bus master; suppresses hits |
| ownAddrCfg | input | NUM_SLOTS*8 | Per-slot address in bits 7:1 of each byte; bit 0 of byte 0 enables general call |
| addrMaskCfg | input | NUM_SLOTS*8 | Per-slot don't-care mask in bits 7:1 of each byte |
| addrValid | output | 1 | Decision for current frame is available |
| addrHit | output | 1 | Some slot matched |
| hitSlot | output | SLOT_W | Lowest matching slot index |
| gcHit | output | 1 | General call recognized |
| rwBit | output | 1 | Captured direction bit |

## Verification
The bound checker checks several rules on every cycle. A slot index is only nonzero alongside a hit. No hit appears without a valid decision. A START or STOP strobe always empties the decision on the next edge. A decision taken in master mode carries no hit. A general-call hit requires the enable bit. A held decision stays unchanged until it is cleared. Only the bench scenarios can show the rest. These are the mask arithmetic on real address patterns, the choice of the lowest slot among overlapping slots, the exact three-edge latency from the pin, and the data-phase bytes that leave the result untouched.

// File: rtl/i2c_tgt_addr_pkg.sv
package i2c_tgt_addr_pkg;
  // Strobes from the bus-sequencing control to the address datapath
  typedef struct packed {
    logic frameStart;  // START seen: restart capture
    logic shiftBit;    // sample one address bit
    logic lastBit;     // eighth bit: take the decision
    logic clearAll;    // START or STOP: drop decision
    logic sdaBit;      // synchronized SDA level
  } ctrlStb_t;
endpackage

// File: rtl/i2c_tgt_addr_ctrl.sv
module i2c_tgt_addr_ctrl
  import i2c_tgt_addr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  output ctrlStb_t strobe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [1:0]       sclSync, sdaSync;
  logic             sclPrev, sdaPrev;
  logic             armed;
  logic [CNT_W-1:0] bitCnt;
  logic             sclNow, sdaNow, sclRise, startDet, stopDet, takeBit, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  always_comb begin
    sclNow   = sclSync[1];
    sdaNow   = sdaSync[1];
    sclRise  = sclNow & ~sclPrev;
    startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    takeBit  = sclRise & armed;
    lastBit  = takeBit & (bitCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      bitCnt <= '0;
    end else if (startDet) begin
      armed  <= 1'b1;
      bitCnt <= '0;
    end else if (stopDet) begin
      armed  <= 1'b0;
    end else if (takeBit) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) armed <= 1'b0;
    end
  end

  always_comb begin
    strobe.frameStart = startDet;
    strobe.shiftBit   = takeBit & ~lastBit;
    strobe.lastBit    = lastBit;
    strobe.clearAll   = startDet | stopDet;
    strobe.sdaBit     = sdaNow;
  end
endmodule

// File: rtl/i2c_tgt_addr_dp.sv
module i2c_tgt_addr_dp
  import i2c_tgt_addr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 7,
  parameter int SLOT_W    = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStb_t                          strobe,
  input  logic                              masterMode,
  input  logic [NUM_SLOTS*(ADDR_W+1)-1:0]   ownAddrCfg,
  input  logic [NUM_SLOTS*(ADDR_W+1)-1:0]   addrMaskCfg,
  output logic                              addrValid,
  output logic                              addrHit,
  output logic [SLOT_W-1:0]                 hitSlot,
  output logic                              gcHit,
  output logic                              rwBit
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [ADDR_W-1:0]    shiftReg;
  logic [NUM_SLOTS-1:0] slotMatch;
  logic [SLOT_W-1:0]    encSlot;
  logic                 anyHit, gcMatch, qualHit;
  logic [NUM_SLOTS-1:0] unusedCfgBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.frameStart) shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {shiftReg[ADDR_W-2:0], strobe.sdaBit};
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    logic [ADDR_W-1:0] slotAddr, slotMask;
    assign slotAddr     = ownAddrCfg[g*BYTE_W+1 +: ADDR_W];
    assign slotMask     = addrMaskCfg[g*BYTE_W+1 +: ADDR_W];
    assign slotMatch[g] = ((shiftReg ^ slotAddr) & ~slotMask) == '0;
    if (g == 0) begin : gFirst
      assign unusedCfgBits[g] = addrMaskCfg[g*BYTE_W];
    end else begin : gRest
      assign unusedCfgBits[g] = addrMaskCfg[g*BYTE_W] ^ ownAddrCfg[g*BYTE_W];
    end
  end

  always_comb begin
    encSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (slotMatch[i]) encSlot = SLOT_W'(i);
    anyHit  = |slotMatch;
    gcMatch = ownAddrCfg[0] & (shiftReg == '0) & ~strobe.sdaBit;
    qualHit = anyHit & ~masterMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrHit   <= 1'b0;
      hitSlot   <= '0;
      gcHit     <= 1'b0;
      rwBit     <= 1'b0;
    end else if (strobe.clearAll) begin
      addrValid <= 1'b0;
      addrHit   <= 1'b0;
      hitSlot   <= '0;
      gcHit     <= 1'b0;
      rwBit     <= 1'b0;
    end else if (strobe.lastBit) begin
      addrValid <= 1'b1;
      addrHit   <= qualHit;
      hitSlot   <= qualHit ? encSlot : '0;
      gcHit     <= gcMatch & ~masterMode;
      rwBit     <= strobe.sdaBit;
    end
  end
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tgt_addr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 7,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sclIn,
  input  logic                            sdaIn,
  input  logic                            masterMode,
  input  logic [NUM_SLOTS*(ADDR_W+1)-1:0] ownAddrCfg,
  input  logic [NUM_SLOTS*(ADDR_W+1)-1:0] addrMaskCfg,
  output logic                            addrValid,
  output logic                            addrHit,
  output logic [SLOT_W-1:0]               hitSlot,
  output logic                            gcHit,
  output logic                            rwBit
);
  ctrlStb_t strobe;

  i2c_tgt_addr_ctrl #(.BYTE_W(ADDR_W + 1)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe)
  );

  i2c_tgt_addr_dp #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .masterMode(masterMode),
    .ownAddrCfg(ownAddrCfg), .addrMaskCfg(addrMaskCfg),
    .addrValid(addrValid), .addrHit(addrHit), .hitSlot(hitSlot),
    .gcHit(gcHit), .rwBit(rwBit)
  );
endmodule

// File: rtl/i2c_tgt_addr_chk.sv
module i2c_tgt_addr_chk #(
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearStb,
  input logic              masterMode,
  input logic              gcEnable,
  input logic              addrValid,
  input logic              addrHit,
  input logic [SLOT_W-1:0] hitSlot,
  input logic              gcHit
);
  AST_SLOT_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !addrHit |-> hitSlot == '0);  // R5

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit || gcHit) |-> addrValid);  // R4

  AST_CLEAR_ON_COND: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> !addrValid && !addrHit && !gcHit);  // R1

  AST_MASTER_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(addrValid) && $past(masterMode)) |-> !addrHit && !gcHit);  // R8

  AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gcHit) |-> $past(gcEnable));  // R6

  AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !clearStb) |=> addrValid && $stable(addrHit) && $stable(hitSlot) && $stable(gcHit));  // R9
endmodule

bind i2c_tgt_addr_match i2c_tgt_addr_chk #(.SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rstN(rstN), .clearStb(strobe.clearAll), .masterMode(masterMode),
  .gcEnable(ownAddrCfg[0]), .addrValid(addrValid), .addrHit(addrHit),
  .hitSlot(hitSlot), .gcHit(gcHit)
);

// File: tb/i2c_tgt_addr_match_tb.sv
module i2c_tgt_addr_match_tb_top;
  localparam int NS = 4;

  logic clk = 0, rstN = 0, sclIn = 1, sdaIn = 1, masterMode = 0;
  logic [NS*8-1:0] ownAddrCfg, addrMaskCfg;
  logic addrValid, addrHit, gcHit, rwBit;
  logic [1:0] hitSlot;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic hit; logic [1:0] slot; logic gc; logic rw; string tag; } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  i2c_tgt_addr_match dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .masterMode(masterMode),
    .ownAddrCfg(ownAddrCfg), .addrMaskCfg(addrMaskCfg), .addrValid(addrValid),
    .addrHit(addrHit), .hitSlot(hitSlot), .gcHit(gcHit), .rwBit(rwBit)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Reference model from the requirements (R3..R6, R8)
  function automatic exp_t model(logic [7:0] b, logic mst, string tag);
    exp_t e;
    e.hit = 0; e.slot = 0; e.rw = b[0]; e.tag = tag;
    for (int s = NS - 1; s >= 0; s--) begin
      logic [6:0] a, m;
      a = ownAddrCfg[s*8+1 +: 7];
      m = addrMaskCfg[s*8+1 +: 7];
      if (((b[7:1] ^ a) & ~m) == 0) begin e.hit = 1; e.slot = 2'(s); end
    end
    e.gc = ownAddrCfg[0] && (b == 8'h00);
    if (mst) begin e.hit = 0; e.slot = 0; e.gc = 0; end
    return e;
  endfunction

  task automatic busStart();
    sdaIn = 1; waitN(2); sclIn = 1; waitN(4);
    sdaIn = 0; waitN(4);
    sclIn = 0; waitN(2);
  endtask

  task automatic busStop();
    sdaIn = 0; waitN(2); sclIn = 1; waitN(4);
    sdaIn = 1; waitN(4);
  endtask

  // Driver: push expectation, then clock the address byte out MSB first
  task automatic sendFrame(logic [7:0] b, logic mst, string tag);
    masterMode = mst;
    expQ.push_back(model(b, mst, tag));
    for (int i = 7; i >= 0; i--) begin
      sdaIn = b[i]; waitN(4);
      sclIn = 1;
      if (i == 0) begin
        waitN(2); chk("R7", "valid low after 2 edges", int'(addrValid), 0);
        waitN(1); chk("R7", "valid high after 3 edges", int'(addrValid), 1);
        waitN(1);
      end else waitN(4);
      sclIn = 0; waitN(2);
    end
  endtask

  // Data phase: nine more SCL pulses must leave the decision alone (R9)
  task automatic dataPhase(logic [8:0] bits);
    logic [4:0] snap;
    snap = {addrValid, addrHit, hitSlot, gcHit};
    for (int i = 8; i >= 0; i--) begin
      sdaIn = bits[i]; waitN(3);
      sclIn = 1; waitN(4);
      sclIn = 0; waitN(2);
    end
    chk("R9", "outputs after data phase", int'({addrValid, addrHit, hitSlot, gcHit}), int'(snap));
  endtask

  // Monitor: pop an expectation on each new decision
  logic validSeen = 0;
  always @(negedge clk) begin
    if (rstN && addrValid && !validSeen) begin
      if (expQ.size() == 0) begin
        chk("R2", "unexpected decision", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk("R4", {e.tag, " hit"}, int'(addrHit), int'(e.hit));
        chk("R5", {e.tag, " slot"}, int'(hitSlot), int'(e.slot));
        chk("R6", {e.tag, " gc"}, int'(gcHit), int'(e.gc));
        chk("R2", {e.tag, " rw"}, int'(rwBit), int'(e.rw));
      end
    end
    validSeen = addrValid;
  end

  initial begin
    // slot0 0x50 exact + general call, slot1 0x20 low two bits don't-care,
    // slot2 0x21 exact, slot3 0x3C with bit 6 don't-care
    ownAddrCfg  = {8'h3C << 1, 8'h21 << 1, 8'h20 << 1, (8'h50 << 1) | 8'h01};
    addrMaskCfg = {8'h40 << 1, 8'h00, 8'h03 << 1, 8'h00};
    waitN(5);
    rstN = 1;
    waitN(1);
    chk("R10", "reset outputs", int'({addrValid, addrHit, hitSlot, gcHit, rwBit}), 0);

    busStart();
    sendFrame({7'h50, 1'b0}, 0, "R3 exact slot0 write");
    dataPhase(9'h14B);
    busStop();
    chk("R1", "cleared by STOP", int'({addrValid, addrHit, hitSlot, gcHit, rwBit}), 0);

    busStart();
    sendFrame({7'h22, 1'b1}, 0, "R3 masked slot1 read");
    dataPhase(9'h0F0);
    busStart();
    chk("R1", "cleared by repeated START", int'({addrValid, addrHit, hitSlot, gcHit, rwBit}), 0);
    sendFrame({7'h21, 1'b0}, 0, "R5 overlap slot1 and slot2");
    busStop();

    busStart();
    sendFrame({7'h7C, 1'b1}, 0, "R3 slot3 masked bit6");
    busStart();
    sendFrame({7'h11, 1'b0}, 0, "R4 no slot hit");
    busStart();
    sendFrame(8'h00, 0, "R6 general call");
    busStop();

    busStart();
    sendFrame({7'h50, 1'b1}, 1, "R8 master mode");
    busStop();
    masterMode = 0;

    ownAddrCfg[0] = 1'b0;
    busStart();
    sendFrame(8'h00, 0, "R6 general call disabled");
    busStop();

    waitN(4);
    chk("R2", "all decisions seen", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule